// File: doc/BRIEF.md
# Receiver idle timeout detector

This block watches a serial receive path for silence. Once a character has been received, it counts baud-clock periods. If the count reaches a programmed limit before the next character begins, it raises a timeout flag. The flag stays set until software clears it. The block does not contain the deserializer, the baud generator or the register interface. It only takes their strobes: a one-cycle baud tick, a start-bit-detected pulse and an end-of-character pulse. A flag-clear pulse also arrives from outside.

The reference point of the measurement depends on the mode. In standard mode the count starts when a character has been fully received. A new start bit stops the count until the next character ends. In smart card mode the count starts at the start bit of each character, and every new start bit restarts it. This lets one limit serve as both the character waiting time and the block waiting time.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `timeout_o` is 0 and `idle_cnt_o` is 0.
- R2: In standard mode (`smartcard_i`=0), an `char_end_i` pulse zeroes the counter and arms it. While armed, the counter rises by one per clock cycle in which `baud_tick_i` is high, and never on cycles without a tick.
- R3: In standard mode, a `start_seen_i` pulse zeroes the counter and disarms it. It stays at zero until the next `char_end_i`.
- R4: In smart card mode (`smartcard_i`=1), a `start_seen_i` pulse zeroes and arms the counter. `char_end_i` has no effect on the counter in this mode.
- R5: When a baud tick brings the count equal to a nonzero `limit_i`, `timeout_o` goes to 1 on the same clock edge as the count. Both outputs are registered, one clock after the inputs that cause them.
- R6: `timeout_o` stays at 1 until a `timeout_clr_i` pulse. If a clear and a new set occur in the same cycle, the flag ends at 1.
- R7: Once the count equals the limit, it holds at the limit on further ticks and produces no new set. A clear issued then leaves the flag at 0.
- R8: With `limit_i`=0, the counter stays at zero and `timeout_o` never sets.
- R9: While `enable_i`=0, the counter is zero and disarmed, and `timeout_o` keeps its value. After enable rises, ticks do nothing until a reference strobe arrives.
- R10: A reference strobe in the same cycle as a baud tick wins: the counter ends at zero.
- R11: The limit and counter width is `CNT_W` bits, 24 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Detector enable |
| baud_tick_i | input | 1 | One-cycle pulse per baud period |
| start_seen_i | input | 1 | Start bit detected pulse |
| char_end_i | input | 1 | Character fully received pulse |
| smartcard_i | input | 1 | 0 selects standard mode, 1 selects smart card mode |
| timeout_clr_i | input | 1 | Flag clear pulse |
| limit_i | input | CNT_W | Timeout limit in baud periods, 0 disables detection |
| timeout_o | output | 1 | Sticky timeout flag |
| idle_cnt_o | output | CNT_W | Live counter value |

## Verification
The bench builds the block with `CNT_W`=8. This makes the full-scale limit of 255 reachable within a few hundred ticks, so it can show the flag firing exactly at the top value and the count saturating there instead of wrapping. Small limits of 0, 1 and 3 exercise the following cases:
- the disabled case;
- a set colliding with a clear;
- mode-dependent restarts;
- strobes arriving together with a tick.

// File: rtl/rx_idle_timer_pkg.sv
package rx_idle_timer_pkg;

    typedef enum logic {
        REF_AT_END   = 1'b0,
        REF_AT_START = 1'b1
    } ref_mode_e;

    typedef struct packed {
        logic armed;
    } arm_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/rx_idle_timer_arm.sv
module rx_idle_timer_arm
    import rx_idle_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic mode_i,
    input  logic start_i,
    input  logic end_i,
    output logic armed_o,
    output logic restart_o
);

    ref_mode_e  mode;
    arm_state_t st_d, st_q;

    assign mode = ref_mode_e'(mode_i);

    always_comb begin
        st_d      = st_q;
        restart_o = 1'b0;
        if (!enable_i) begin
            st_d.armed = 1'b0;
            restart_o  = 1'b1;
        end else if (mode == REF_AT_START) begin
            if (start_i) begin
                st_d.armed = 1'b1;
                restart_o  = 1'b1;
            end
        end else begin
            if (end_i) begin
                st_d.armed = 1'b1;
                restart_o  = 1'b1;
            end else if (start_i) begin
                st_d.armed = 1'b0;
                restart_o  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;

    // R9: disabling always disarms
    a_r9_disarm_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !armed_o);

    // R3: standard-mode start bit without end strobe disarms
    a_r3_std_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !mode_i && start_i && !end_i) |=> !armed_o);

    // R4: smart card start bit arms
    a_r4_sc_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && mode_i && start_i) |=> armed_o);

endmodule

// File: rtl/rx_idle_timer_count.sv
module rx_idle_timer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic             below;
    logic             step;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d  = st_q;
        below = (st_q.cnt < limit_i);
        step  = run_i && tick_i && !restart_i && below;
        nxt   = st_q.cnt + ONE;
        hit_o = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = nxt;
            hit_o    = (nxt == limit_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R2: one step per armed tick
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !restart_i && cnt_o < limit_i) |=> cnt_o == $past(cnt_o) + ONE);

    // R7/R8: at or above the limit the count holds
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && cnt_o >= limit_i) |=> $stable(cnt_o));

    // R10: restart wins over a tick
    a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_o == '0);

    // R2: no tick, no change
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(cnt_o));

endmodule

// File: rtl/rx_idle_timer_flag.sv
module rx_idle_timer_flag
    import rx_idle_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R6: sticky without clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R6: set beats clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             baud_tick_i,
    input  logic             start_seen_i,
    input  logic             char_end_i,
    input  logic             smartcard_i,
    input  logic             timeout_clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             timeout_o,
    output logic [CNT_W-1:0] idle_cnt_o
);

    logic armed;
    logic restart;
    logic hit;

    rx_idle_timer_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .mode_i    (smartcard_i),
        .start_i   (start_seen_i),
        .end_i     (char_end_i),
        .armed_o   (armed),
        .restart_o (restart)
    );

    rx_idle_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (armed),
        .tick_i    (baud_tick_i),
        .restart_i (restart),
        .limit_i   (limit_i),
        .cnt_o     (idle_cnt_o),
        .hit_o     (hit)
    );

    rx_idle_timer_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (timeout_clr_i),
        .flag_o (timeout_o)
    );

    // R8: a zero limit never raises the flag
    a_r8_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_o && limit_i == '0) |=> !timeout_o);

    // R9: disabled means zero count
    a_r9_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> idle_cnt_o == '0);

    // R5: the flag rises only with the count at the limit
    a_r5_rise_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> idle_cnt_o == $past(limit_i));

endmodule

// File: tb/tb_rx_idle_timer.sv
module tb_rx_idle_timer;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable_i = 1'b0;
    logic         baud_tick_i = 1'b0;
    logic         start_seen_i = 1'b0;
    logic         char_end_i = 1'b0;
    logic         smartcard_i = 1'b0;
    logic         timeout_clr_i = 1'b0;
    logic [W-1:0] limit_i = '0;
    logic         timeout_o;
    logic [W-1:0] idle_cnt_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rx_idle_timer #(.CNT_W(W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .baud_tick_i   (baud_tick_i),
        .start_seen_i  (start_seen_i),
        .char_end_i    (char_end_i),
        .smartcard_i   (smartcard_i),
        .timeout_clr_i (timeout_clr_i),
        .limit_i       (limit_i),
        .timeout_o     (timeout_o),
        .idle_cnt_o    (idle_cnt_o)
    );

    // Vector: {en,tick,start,end,sc,clr}, limit, exp flag, exp count
    localparam int NV = 31;
    localparam logic [22:0] VEC [NV] = '{
        {6'b100000, 8'd3, 1'b0, 8'd0},  // R9 idle after enable
        {6'b110000, 8'd3, 1'b0, 8'd0},  // R9 tick before any char
        {6'b100100, 8'd3, 1'b0, 8'd0},  // R2 end arms
        {6'b110000, 8'd3, 1'b0, 8'd1},  // R2
        {6'b110000, 8'd3, 1'b0, 8'd2},  // R2
        {6'b110000, 8'd3, 1'b1, 8'd3},  // R5 hit
        {6'b110000, 8'd3, 1'b1, 8'd3},  // R7 saturate
        {6'b100001, 8'd3, 1'b0, 8'd3},  // R6 clear
        {6'b111000, 8'd3, 1'b0, 8'd0},  // R3 start stops
        {6'b110000, 8'd3, 1'b0, 8'd0},  // R3 stays idle
        {6'b100100, 8'd3, 1'b0, 8'd0},  // R2 rearm
        {6'b110000, 8'd3, 1'b0, 8'd1},  // R2
        {6'b111000, 8'd3, 1'b0, 8'd0},  // R10 start with tick
        {6'b110000, 8'd3, 1'b0, 8'd0},  // R3
        {6'b101010, 8'd3, 1'b0, 8'd0},  // R4 sc start arms
        {6'b110010, 8'd3, 1'b0, 8'd1},  // R4
        {6'b100110, 8'd3, 1'b0, 8'd1},  // R4 end ignored
        {6'b110010, 8'd3, 1'b0, 8'd2},  // R4
        {6'b111010, 8'd3, 1'b0, 8'd0},  // R10 sc restart with tick
        {6'b110010, 8'd3, 1'b0, 8'd1},  // R4
        {6'b110010, 8'd3, 1'b0, 8'd2},  // R4
        {6'b110010, 8'd3, 1'b1, 8'd3},  // R5 sc hit
        {6'b110011, 8'd3, 1'b0, 8'd3},  // R7 no re-set when saturated
        {6'b101010, 8'd0, 1'b0, 8'd0},  // R8 zero limit
        {6'b110010, 8'd0, 1'b0, 8'd0},  // R8
        {6'b110010, 8'd0, 1'b0, 8'd0},  // R8
        {6'b110011, 8'd1, 1'b1, 8'd1},  // R6 set beats clear
        {6'b000000, 8'd1, 1'b1, 8'd0},  // R9 disable keeps flag
        {6'b010000, 8'd1, 1'b1, 8'd0},  // R9 tick while off
        {6'b100001, 8'd1, 1'b0, 8'd0},  // R9 re-enable, clear
        {6'b110000, 8'd1, 1'b0, 8'd0}   // R9 idle after re-enable
    };

    task automatic check(input string req, input logic gf, input logic [W-1:0] gc,
                         input logic ef, input logic [W-1:0] ec);
        n_vec++;
        if (gf !== ef || gc !== ec) begin
            n_fail++;
            $display("FAIL %s: flag=%0b count=%0d, expected flag=%0b count=%0d",
                     req, gf, gc, ef, ec);
        end
    endtask

    task automatic drive(input logic [5:0] c, input logic [W-1:0] lim);
        {enable_i, baud_tick_i, start_seen_i, char_end_i, smartcard_i, timeout_clr_i} = c;
        limit_i = lim;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", timeout_o, idle_cnt_o, 1'b0, 8'd0);  // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", timeout_o, idle_cnt_o, 1'b0, 8'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][22:17], VEC[i][16:9]);
            @(negedge clk);
            check($sformatf("vector %0d", i), timeout_o, idle_cnt_o, VEC[i][8], VEC[i][7:0]);
        end

        // R11/R5/R7: full-scale limit, standard mode
        drive(6'b100100, 8'd255);
        @(negedge clk);
        for (int k = 0; k < 254; k++) begin
            drive(6'b110000, 8'd255);
            @(negedge clk);
        end
        check("R11", timeout_o, idle_cnt_o, 1'b0, 8'd254);
        drive(6'b110000, 8'd255);
        @(negedge clk);
        check("R5", timeout_o, idle_cnt_o, 1'b1, 8'd255);
        drive(6'b110000, 8'd255);
        @(negedge clk);
        check("R7", timeout_o, idle_cnt_o, 1'b1, 8'd255);

        // R2: no tick means no advance
        drive(6'b100100, 8'd5);
        @(negedge clk);
        drive(6'b100000, 8'd5);
        repeat (4) @(negedge clk);
        check("R2", timeout_o, idle_cnt_o, 1'b1, 8'd0);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", timeout_o, idle_cnt_o, 1'b0, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule